// File: doc/BRIEF.md
# Byte Parity Generator and Checker

This block guards a 36-bit word, split into four 9-bit lanes, against single-bit corruption while the word is held in storage. It has two independent streaming paths. On the write path, a word flows from a producer toward storage. When generation is turned on, each lane's top bit is replaced by a parity bit computed over that lane's eight lower bits. On the read path, a word flows from storage toward a consumer. Every lane of every word is checked, and a single error flag travels alongside the word.

One mode register decides whether each lane must hold an odd or an even number of ones. Reset leaves it on odd. A one-cycle load strobe can set it to even or return it to odd. Both paths use the current mode. Each path is one valid/ready register stage, so the block can sit in line between a producer, a memory and a consumer with no extra glue.

Back-pressure rules apply to both paths. An input word is taken on a clock edge where its valid and the stage's ready are both high. Ready is high whenever the stage is empty, or when the stage's word is being taken downstream at that same edge. A word that is offered but not taken must stay stable until it is taken. Once the stage's output is valid it does not change until its consumer's ready is high.

Top module: `bpar_top`

## Requirements
- R1: After reset, `mem_valid` and `out_valid` are 0, `wr_ready` and `rd_ready` are 1, and the parity mode is odd.
- R2: For a write word taken while `gen_en` is 1, lane i occupies bits [9i+8:9i]. Bit 9i+8 of `mem_data` is replaced so that the lane's nine bits hold an odd number of ones in odd mode, or an even number in even mode. Bits [9i+7:9i] are copied unchanged.
- R3: For a write word taken while `gen_en` is 0, `mem_data` equals `wr_data` bit for bit.
- R4: A clock edge with `cfg_load` = 1 sets the mode to even when `cfg_even` = 1 and to odd when `cfg_even` = 0. At any other edge the mode keeps its value.
- R5: For a read word, `out_data` equals `rd_data`. `out_perr` is 1 exactly when at least one lane's nine bits disagree with the mode: an even count of ones in odd mode, or an odd count in even mode.
- R6: A word taken at a clock edge is presented, with its error flag, from that edge on, so the output is valid one cycle after the transfer.
- R7: While an output is valid and its ready is 0, the output word and `out_perr` stay unchanged. Input ready is 1 exactly when the stage is empty or its output is being taken. No word is lost or duplicated.
- R8: A mode load applies to words taken at later edges. A word already held in a stage keeps the value it was given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both paths |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Strobe that loads the parity mode |
| cfg_even | input | 1 | Mode to load: 1 even, 0 odd |
| gen_en | input | 1 | Replace lane top bits with generated parity |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write stage can take a word |
| wr_data | input | 36 | Write word from producer |
| mem_valid | output | 1 | Word toward storage is valid |
| mem_ready | input | 1 | Storage takes the word |
| mem_data | output | 36 | Word toward storage, parity applied |
| rd_valid | input | 1 | Word from storage offered |
| rd_ready | output | 1 | Read stage can take a word |
| rd_data | input | 36 | Word read from storage |
| out_valid | output | 1 | Checked word valid |
| out_ready | input | 1 | Consumer takes the checked word |
| out_data | output | 36 | Checked word |
| out_perr | output | 1 | Some lane of `out_data` failed parity |

## Verification
Every result is due exactly one cycle after the edge that takes its input. This covers the generated word, the passed-through word and the error flag. A mode load takes effect for the transfer at the following edge. The bench drives inputs at the falling edge, lets one rising edge pass, and samples at the next falling edge, so each expected value is read in the cycle it first becomes due. The stall tests hold ready low for extra cycles and sample while stalled. They show that the held word stays put through a mode change and that it leaves without being repeated once ready returns.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
  typedef enum logic {
    PAR_ODD  = 1'b0,
    PAR_EVEN = 1'b1
  } par_mode_e;
endpackage

// File: rtl/bpar_mode.sv
module bpar_mode
  import bpar_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  logic      even,
  output par_mode_e mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= PAR_ODD;
    end else if (load) begin
      mode <= even ? PAR_EVEN : PAR_ODD;
    end
  end
endmodule

// File: rtl/bpar_lanes.sv
// Per-lane parity logic. GEN=1 rewrites each lane's top bit; GEN=0 flags
// lanes whose nine bits disagree with the mode.
module bpar_lanes
  import bpar_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9,
  parameter bit GEN    = 1'b1
) (
  input  par_mode_e                 mode,
  input  logic                      enable,
  input  logic [BYTES*BYTE_W-1:0]   din,
  output logic [BYTES*BYTE_W-1:0]   dout,
  output logic                      err
);
  localparam int DATA_W = BYTE_W - 1;

  logic             odd_sel;
  logic [BYTES-1:0] lane_err;

  assign odd_sel = (mode == PAR_ODD);

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    logic [DATA_W-1:0] low;
    assign low = din[i*BYTE_W +: DATA_W];
    if (GEN) begin : g_gen
      assign dout[i*BYTE_W +: DATA_W] = low;
      assign dout[i*BYTE_W + DATA_W]  = enable ? ((^low) ^ odd_sel)
                                               : din[i*BYTE_W + DATA_W];
      assign lane_err[i] = 1'b0;
    end else begin : g_chk
      assign dout[i*BYTE_W +: BYTE_W] = din[i*BYTE_W +: BYTE_W];
      assign lane_err[i] = enable & ((^din[i*BYTE_W +: BYTE_W]) ^ odd_sel);
    end
  end

  assign err = |lane_err;
endmodule

// File: rtl/bpar_slice.sv
module bpar_slice #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= in_data;
      end
    end
  end
endmodule

// File: rtl/bpar_top.sv
module bpar_top
  import bpar_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_load,
  input  logic                    cfg_even,
  input  logic                    gen_en,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [BYTES*BYTE_W-1:0] wr_data,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [BYTES*BYTE_W-1:0] mem_data,
  input  logic                    rd_valid,
  output logic                    rd_ready,
  input  logic [BYTES*BYTE_W-1:0] rd_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [BYTES*BYTE_W-1:0] out_data,
  output logic                    out_perr
);
  localparam int WORD_W = BYTES * BYTE_W;

  par_mode_e         par_mode;
  logic [WORD_W-1:0] gen_word;
  logic [WORD_W-1:0] chk_word;
  logic              chk_err;
  logic              gen_unused;

  bpar_mode u_mode (
    .clk  (clk),
    .rst_n(rst_n),
    .load (cfg_load),
    .even (cfg_even),
    .mode (par_mode)
  );

  bpar_lanes #(.BYTES(BYTES), .BYTE_W(BYTE_W), .GEN(1'b1)) u_gen (
    .mode  (par_mode),
    .enable(gen_en),
    .din   (wr_data),
    .dout  (gen_word),
    .err   (gen_unused)
  );

  bpar_slice #(.W(WORD_W)) u_wr_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (wr_valid),
    .in_ready (wr_ready),
    .in_data  (gen_word),
    .out_valid(mem_valid),
    .out_ready(mem_ready),
    .out_data (mem_data)
  );

  bpar_lanes #(.BYTES(BYTES), .BYTE_W(BYTE_W), .GEN(1'b0)) u_chk (
    .mode  (par_mode),
    .enable(1'b1),
    .din   (rd_data),
    .dout  (chk_word),
    .err   (chk_err)
  );

  bpar_slice #(.W(WORD_W + 1)) u_rd_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rd_valid),
    .in_ready (rd_ready),
    .in_data  ({chk_err, chk_word}),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data ({out_perr, out_data})
  );
endmodule

// File: rtl/bpar_sva.sv
module bpar_sva
  import bpar_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_load,
  input logic                    cfg_even,
  input logic                    gen_en,
  input logic                    wr_valid,
  input logic                    wr_ready,
  input logic [BYTES*BYTE_W-1:0] wr_data,
  input logic                    mem_valid,
  input logic                    mem_ready,
  input logic [BYTES*BYTE_W-1:0] mem_data,
  input logic                    rd_valid,
  input logic                    rd_ready,
  input logic [BYTES*BYTE_W-1:0] rd_data,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [BYTES*BYTE_W-1:0] out_data,
  input logic                    out_perr,
  input par_mode_e               par_mode
);
  localparam int WORD_W = BYTES * BYTE_W;

  function automatic logic word_bad(input logic [WORD_W-1:0] w, input logic odd);
    logic e;
    e = 1'b0;
    for (int i = 0; i < BYTES; i++) e |= (^w[i*BYTE_W +: BYTE_W]) == !odd;
    return e;
  endfunction

  function automatic logic [WORD_W-1:0] low_only(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] m;
    m = w;
    for (int i = 0; i < BYTES; i++) m[i*BYTE_W + BYTE_W - 1] = 1'b0;
    return m;
  endfunction

  AST_RESET_IDLE: assert property (@(posedge clk)
    $rose(rst_n) |-> !mem_valid && !out_valid && par_mode == PAR_ODD); // R1

  AST_GEN_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && gen_en |=>
      !word_bad(mem_data, $past(par_mode) == PAR_ODD) &&
      low_only(mem_data) == low_only($past(wr_data))); // R2

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && !gen_en |=> mem_data == $past(wr_data)); // R3

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> par_mode == ($past(cfg_even) ? PAR_EVEN : PAR_ODD)); // R4

  AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(par_mode)); // R4

  AST_CHK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=>
      out_data == $past(rd_data) &&
      out_perr == word_bad(out_data, $past(par_mode) == PAR_ODD)); // R5

  AST_WR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> mem_valid); // R6

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> out_valid); // R6

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_data)); // R7

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_perr)); // R7
endmodule

bind bpar_top bpar_sva #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_even(cfg_even),
  .gen_en(gen_en), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_data(mem_data),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_perr(out_perr), .par_mode(par_mode)
);

// File: tb/tb_bpar_top.sv
module tb_bpar_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0, cfg_even = 1'b0, gen_en = 1'b0;
  logic        wr_valid = 1'b0, mem_ready = 1'b1, rd_valid = 1'b0, out_ready = 1'b1;
  logic [35:0] wr_data = '0, rd_data = '0;
  logic        wr_ready, mem_valid, rd_ready, out_valid, out_perr;
  logic [35:0] mem_data, out_data;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bpar_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_even(cfg_even),
    .gen_en(gen_en), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_data(mem_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_perr(out_perr)
  );

  typedef struct packed {
    logic        gen;
    logic        even;
    logic [35:0] win;
    logic [35:0] wexp;
    logic [35:0] rin;
    logic        rerr;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b0, 36'h000000000, 36'h804020100, 36'h804020100, 1'b0},
    '{1'b1, 1'b1, 36'h000000000, 36'h000000000, 36'h000000000, 1'b0},
    '{1'b1, 1'b1, 36'hFFFFFFFFF, 36'h7FBFDFEFF, 36'hFFFFFFFFF, 1'b1},
    '{1'b1, 1'b0, 36'h000000101, 36'h804020001, 36'h000000000, 1'b1},
    '{1'b0, 1'b0, 36'h123456789, 36'h123456789, 36'h804020000, 1'b1},
    '{1'b0, 1'b1, 36'h7FBFDFEFF, 36'h7FBFDFEFF, 36'h7FBFDFEFF, 1'b0},
    '{1'b1, 1'b1, 36'h000000001, 36'h000000101, 36'h000000101, 1'b0},
    '{1'b0, 1'b0, 36'h000000000, 36'h000000000, 36'h7FBFDFEFF, 1'b1}
  };

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic even);
    @(negedge clk);
    cfg_load = 1'b1;
    cfg_even = even;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // Offer one word on each path; results are checked one edge later.
  task automatic send(input logic g, input logic [35:0] w, input logic [35:0] r);
    gen_en   = g;
    wr_data  = w;
    rd_data  = r;
    wr_valid = 1'b1;
    rd_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    rd_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    check("R1 mem_valid", {35'b0, mem_valid}, 36'd0);
    check("R1 out_valid", {35'b0, out_valid}, 36'd0);
    check("R1 wr_ready", {35'b0, wr_ready}, 36'd1);
    check("R1 rd_ready", {35'b0, rd_ready}, 36'd1);
    // R1: default mode is odd without any load
    send(1'b1, 36'h000000000, 36'hFFFFFFFFF);
    check("R1 default odd gen", mem_data, 36'h804020100);
    check("R1 default odd chk", {35'b0, out_perr}, 36'd0);

    // Table walk: R2 R3 R4 R5 R6
    foreach (VECS[i]) begin
      set_mode(VECS[i].even);
      send(VECS[i].gen, VECS[i].win, VECS[i].rin);
      check("R6 mem_valid", {35'b0, mem_valid}, 36'd1);
      check(VECS[i].gen ? "R2 gen word" : "R3 pass word", mem_data, VECS[i].wexp);
      check("R6 out_valid", {35'b0, out_valid}, 36'd1);
      check("R5 out_data", out_data, VECS[i].rin);
      check(VECS[i].even ? "R4 R5 even flag" : "R4 R5 odd flag", {35'b0, out_perr},
            {35'b0, VECS[i].rerr});
    end

    // R7 R8: stall both outputs, change the mode under a held word
    set_mode(1'b0);
    mem_ready = 1'b0;
    out_ready = 1'b0;
    send(1'b1, 36'h000000000, 36'h000000000);
    check("R7 wr_ready stalled", {35'b0, wr_ready}, 36'd0);
    check("R7 rd_ready stalled", {35'b0, rd_ready}, 36'd0);
    gen_en   = 1'b1;
    wr_data  = 36'hFFFFFFFFF;
    rd_data  = 36'hFFFFFFFFF;
    wr_valid = 1'b1;
    rd_valid = 1'b1;
    cfg_load = 1'b1;
    cfg_even = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    check("R8 held mem_data", mem_data, 36'h804020100);
    check("R8 held out_perr", {35'b0, out_perr}, 36'd1);
    @(negedge clk);
    check("R7 held mem_valid", {35'b0, mem_valid}, 36'd1);
    check("R7 held mem_data", mem_data, 36'h804020100);
    mem_ready = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    rd_valid = 1'b0;
    check("R8 next word even gen", mem_data, 36'h7FBFDFEFF);
    check("R8 next word even chk", {35'b0, out_perr}, 36'd1);
    check("R7 out_data next", out_data, 36'hFFFFFFFFF);
    @(negedge clk);
    check("R7 no duplicate mem", {35'b0, mem_valid}, 36'd0);
    check("R7 no duplicate out", {35'b0, out_valid}, 36'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule